// File: doc/BRIEF.md
# Management-Bus PHY Discovery Sequencer

After a reset, this sequencer finds the lowest-addressed Ethernet PHY on the management bus. It does not drive MDIO. It has a request/acknowledge port to an MDIO master and issues one identifier-register read at a time. It walks the 32 PHY addresses upward. A PHY counts as present when its low identifier register returns anything other than the absence code. The sequencer then reads the high identifier register at the same address and joins the two halves into a 32-bit identifier.

A PHY may still be recovering from its own reset. If a complete sweep finds no PHY, the sequencer waits a fixed time and sweeps again, up to a bounded number of sweeps. The wait is set in microseconds and converted to clock cycles from the clock frequency parameter.

When the search ends, the sequencer pulses a completion strobe. The result appears on the found flag, the address and the identifier. A comparator flags whether the identifier matches an expected value with the revision nibble masked off. A start pulse from idle launches a new search.

Top module: `phy_scan_top`

## Requirements
- R1: A start pulse while idle launches a search at address 0 with sweep count 1. A start pulse during a search has no effect on the order or number of requests.
- R2: Addresses are visited in ascending order. Each request stays asserted, with stable address and register number, until a cycle in which acknowledge is high. Only one request is outstanding at a time.
- R3: Each address is first read at management register 3. A returned value of 16'hFFFF means no PHY is present there. Any other value causes a read of register 2 at the same address before anything else.
- R4: On a hit, the identifier output equals {register 2 data, register 3 data}, the address output equals the responding address, and the found flag is 1.
- R5: The search stops at the first responding address. No request follows the register 2 read at that address.
- R6: Between sweeps, no request is issued for exactly WAIT_US x CLK_HZ / 1e6 clock cycles, with busy held high.
- R7: After MAX_PASSES sweeps without a hit, the sequencer finishes with found = 0, address = 5'h1F and identifier = 0. The result outputs show these same values during a search.
- R8: Done is high for exactly one cycle at the end of each search. Busy is high from the cycle after an accepted start until the done cycle, in which busy is already low.
- R9: The match output is 1 only when found is 1 and bits 31:4 of the identifier equal bits 31:4 of the expected identifier. Bits 3:0 are ignored.
- R10: After reset the sequencer is idle, with no request, done = 0, found = 0, address = 5'h1F and identifier = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a search when idle |
| mdio_req | output | 1 | Read request to the MDIO master |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Management register number of the request |
| mdio_ack | input | 1 | Request completed, read data valid |
| mdio_rdata | input | 16 | Read data returned with acknowledge |
| expect_id | input | 32 | Identifier to compare against |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| found | output | 1 | A PHY was found |
| phy_addr | output | 5 | Address of the found PHY, 5'h1F if none |
| phy_id | output | 32 | Assembled identifier, 0 if none |
| id_match | output | 1 | Identifier equals expected, revision ignored |

## Verification
The bench builds the sequencer with CLK_HZ = 2,000,000, WAIT_US = 10 and MAX_PASSES = 4. With these values the gap between sweeps is 20 cycles and an exhaustive failing search is 128 reads. Both the full retry bound and a PHY that appears only in a later sweep can therefore be covered within a short run. The measured gap length and the count of reads per sweep are then compared against the figures computed from these parameters.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int ADDR_W = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2 * DATA_W;

    localparam logic [REG_W-1:0]  REG_ID_HI   = 5'd2;
    localparam logic [REG_W-1:0]  REG_ID_LO   = 5'd3;
    localparam logic [DATA_W-1:0] ABSENT_CODE = 16'hFFFF;
    localparam logic [ADDR_W-1:0] LAST_ADDR   = '1;
    localparam logic [ADDR_W-1:0] NONE_ADDR   = '1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2,
        ST_PAUSE = 2'd3
    } scan_state_e;

    function automatic int unsigned wait_cycles(input longint unsigned clk_hz,
                                                input longint unsigned wait_us);
        longint unsigned c;
        c = (clk_hz * wait_us) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/scan_pause_timer.sv
module scan_pause_timer #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = '0;
        expired = 1'b0;
        if (run) begin
            if (cnt_q == LAST) expired = 1'b1;
            else               cnt_d   = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scan_id_compare.sv
module scan_id_compare #(
    parameter int ID_W     = 32,
    parameter int REV_BITS = 4
) (
    input  logic            valid,
    input  logic [ID_W-1:0] actual,
    input  logic [ID_W-1:0] expected,
    output logic            hit
);
    localparam logic [ID_W-1:0] MASK = ~((ID_W'(1) << REV_BITS) - ID_W'(1));

    always_comb hit = valid && ((actual & MASK) == (expected & MASK));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import phy_scan_pkg::*;
#(
    parameter int MAX_PASSES = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    input  logic              pause_done,
    output logic              req,
    output logic [ADDR_W-1:0] req_phy,
    output logic [REG_W-1:0]  req_reg,
    output logic              pause_run,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [ADDR_W-1:0] res_addr,
    output logic [ID_W-1:0]   res_id
);
    localparam int PW = (MAX_PASSES < 2) ? 1 : $clog2(MAX_PASSES);
    localparam logic [PW-1:0] LAST_PASS = PW'(MAX_PASSES - 1);

    typedef struct packed {
        scan_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [PW-1:0]     pass;
        logic [DATA_W-1:0] lo;
        logic              done;
        logic              found;
        logic [ADDR_W-1:0] res_addr;
        logic [ID_W-1:0]   res_id;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st       = ST_RD_LO;
                    s_d.addr     = '0;
                    s_d.pass     = '0;
                    s_d.found    = 1'b0;
                    s_d.res_addr = NONE_ADDR;
                    s_d.res_id   = '0;
                end
            end
            ST_RD_LO: begin
                if (ack) begin
                    if (rdata != ABSENT_CODE) begin
                        s_d.lo = rdata;
                        s_d.st = ST_RD_HI;
                    end else if (s_q.addr != LAST_ADDR) begin
                        s_d.addr = s_q.addr + 1'b1;
                    end else if (s_q.pass == LAST_PASS) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_PAUSE;
                    end
                end
            end
            ST_RD_HI: begin
                if (ack) begin
                    s_d.res_id   = {rdata, s_q.lo};
                    s_d.res_addr = s_q.addr;
                    s_d.found    = 1'b1;
                    s_d.done     = 1'b1;
                    s_d.st       = ST_IDLE;
                end
            end
            ST_PAUSE: begin
                if (pause_done) begin
                    s_d.pass = s_q.pass + 1'b1;
                    s_d.addr = '0;
                    s_d.st   = ST_RD_LO;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.res_addr <= NONE_ADDR;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req       = (s_q.st == ST_RD_LO) || (s_q.st == ST_RD_HI);
        req_phy   = s_q.addr;
        req_reg   = (s_q.st == ST_RD_HI) ? REG_ID_HI : REG_ID_LO;
        pause_run = (s_q.st == ST_PAUSE);
        busy      = (s_q.st != ST_IDLE);
        done      = s_q.done;
        found     = s_q.found;
        res_addr  = s_q.res_addr;
        res_id    = s_q.res_id;
    end
endmodule

// File: rtl/phy_scan_top.sv
module phy_scan_top
    import phy_scan_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 125000000,
    parameter longint unsigned WAIT_US    = 10000,
    parameter int              MAX_PASSES = 11,
    parameter int              REV_BITS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        mdio_req,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata,
    input  logic [31:0] expect_id,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [4:0]  phy_addr,
    output logic [31:0] phy_id,
    output logic        id_match
);
    localparam int unsigned WAIT_CYCLES = wait_cycles(CLK_HZ, WAIT_US);

    logic pause_run;
    logic pause_done;

    scan_sequencer #(.MAX_PASSES(MAX_PASSES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ack       (mdio_ack),
        .rdata     (mdio_rdata),
        .pause_done(pause_done),
        .req       (mdio_req),
        .req_phy   (mdio_phy),
        .req_reg   (mdio_reg),
        .pause_run (pause_run),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .res_addr  (phy_addr),
        .res_id    (phy_id)
    );

    scan_pause_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (pause_run),
        .expired(pause_done)
    );

    scan_id_compare #(.ID_W(ID_W), .REV_BITS(REV_BITS)) u_cmp (
        .valid   (found),
        .actual  (phy_id),
        .expected(expect_id),
        .hit     (id_match)
    );
endmodule

// File: rtl/phy_scan_checker.sv
module phy_scan_checker #(
    parameter int unsigned WAIT_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdio_req,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic        mdio_ack,
    input logic        busy,
    input logic        done,
    input logic        found,
    input logic [4:0]  phy_addr,
    input logic [31:0] phy_id
);
    localparam int GW = $clog2(WAIT_CYCLES + 2);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (busy && !mdio_req) begin
            if (gap_q != '1)       gap_q <= gap_q + 1'b1;
        end else                   gap_q <= '0;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)));

    assert_reg_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> (mdio_reg == 5'd2 || mdio_reg == 5'd3));

    assert_id_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (phy_id[15:0] != 16'hFFFF));

    assert_gap_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && gap_q != '0) |-> (gap_q == GW'(WAIT_CYCLES)));

    assert_none_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (phy_addr == 5'h1F && phy_id == 32'd0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_req);
endmodule

bind phy_scan_top phy_scan_checker #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdio_req(mdio_req),
    .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg),
    .mdio_ack(mdio_ack),
    .busy    (busy),
    .done    (done),
    .found   (found),
    .phy_addr(phy_addr),
    .phy_id  (phy_id)
);

// File: tb/phy_scan_top_test.sv
`timescale 1ns/1ps
module phy_scan_top_test;
    localparam int WAITC  = 20;
    localparam int PASSES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mdio_req;
    logic [4:0]  mdio_phy, mdio_reg;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = '0;
    logic [31:0] expect_id = '0;
    logic        busy, done, found, id_match;
    logic [4:0]  phy_addr;
    logic [31:0] phy_id;

    always #4 clk = ~clk;

    phy_scan_top #(.CLK_HZ(2000000), .WAIT_US(10), .MAX_PASSES(PASSES)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .expect_id(expect_id),
        .busy(busy), .done(done), .found(found), .phy_addr(phy_addr),
        .phy_id(phy_id), .id_match(id_match)
    );

    int checks = 0;
    int fails  = 0;

    // PHY population model
    int          wake_pass [32];
    logic [15:0] id_hi [32];
    logic [15:0] id_lo [32];
    int          pass_ctr = 0;
    int          ack_lat = 1;
    int          lat_cnt = 0;

    // transaction log
    logic [4:0] log_addr [512];
    logic [4:0] log_reg  [512];
    int         log_n = 0;
    int         gaps [16];
    int         gap_n = 0;
    int         gap_run = 0;
    int         done_cnt = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // responder
    initial forever begin
        @(negedge clk);
        if (mdio_ack) begin
            mdio_ack = 1'b0;
        end else if (mdio_req && rst_n) begin
            lat_cnt++;
            if (lat_cnt >= ack_lat) begin
                lat_cnt = 0;
                if (mdio_phy == 5'd0 && mdio_reg == 5'd3) pass_ctr++;
                if (pass_ctr >= wake_pass[mdio_phy])
                    mdio_rdata = (mdio_reg == 5'd3) ? id_lo[mdio_phy] : id_hi[mdio_phy];
                else
                    mdio_rdata = 16'hFFFF;
                mdio_ack = 1'b1;
            end
        end
    end

    // handshake monitor
    initial forever begin
        @(posedge clk);
        if (mdio_req && mdio_ack && log_n < 512) begin
            log_addr[log_n] = mdio_phy;
            log_reg[log_n]  = mdio_reg;
            log_n++;
        end
    end

    // gap and done monitor
    initial forever begin
        @(negedge clk);
        if (done) done_cnt++;
        if (busy && !mdio_req) gap_run++;
        else begin
            if (gap_run != 0 && mdio_req && gap_n < 16) begin
                gaps[gap_n] = gap_run;
                gap_n++;
            end
            gap_run = 0;
        end
    end

    task automatic clear_phys();
        for (int a = 0; a < 32; a++) begin
            wake_pass[a] = 1000;
            id_hi[a] = 16'h0;
            id_lo[a] = 16'hFFFF;
        end
        pass_ctr = 0; log_n = 0; gap_n = 0; done_cnt = 0; lat_cnt = 0;
    endtask

    task automatic add_phy(input int a, input int wp, input logic [15:0] hi, input logic [15:0] lo);
        wake_pass[a] = wp; id_hi[a] = hi; id_lo[a] = lo;
    endtask

    task automatic run_scan(input int poke_at);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            if (n == poke_at) start = 1'b1;
            else              start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
    endtask

    task automatic check_sweep(input string tag, input int first, input int count);
        bit ok = 1'b1;
        for (int i = 0; i < count; i++)
            if (log_addr[first+i] != 5'(i) || log_reg[first+i] != 5'd3) ok = 1'b0;
        check(ok, tag, 32'(first), 32'(first));
    endtask

    task automatic t_reset();
        check(!busy && !mdio_req && !done, "R10 idle", {busy, mdio_req, done}, 0);
        check(!found && phy_addr == 5'h1F && phy_id == 0, "R10 result", {found, phy_addr}, 32'h1F);
    endtask

    task automatic t_basic();
        clear_phys(); ack_lat = 1;
        add_phy(5, 1, 16'h0022, 16'h1617);
        run_scan(-1);
        check(found == 1'b1, "R4 found", found, 1);
        check(phy_addr == 5'd5, "R4 addr", phy_addr, 5);
        check(phy_id == 32'h00221617, "R4 id", phy_id, 32'h00221617);
        check(log_n == 7, "R5 count", log_n, 7);
        check_sweep("R1 R2 ascending from 0", 0, 6);
        check(log_addr[6] == 5'd5 && log_reg[6] == 5'd2, "R3 hi read", {log_addr[6], log_reg[6]}, {5'd5, 5'd2});
        check(!busy, "R8 busy low at done", busy, 0);
        @(negedge clk);
        check(!done && done_cnt == 1, "R8 done one cycle", done_cnt, 1);
        expect_id = 32'h0022161A; #1;
        check(id_match == 1'b1, "R9 rev ignored", id_match, 1);
        expect_id = 32'h00221607; #1;
        check(id_match == 1'b0, "R9 bit4 differs", id_match, 0);
        repeat (3) @(negedge clk);
        check(log_n == 7 && !mdio_req, "R5 no more requests", log_n, 7);
    endtask

    task automatic t_edges();
        clear_phys(); ack_lat = 2;
        add_phy(0, 1, 16'hABCD, 16'h0001);
        run_scan(-1);
        check(found && phy_addr == 0 && phy_id == 32'hABCD0001, "R4 addr 0", phy_id, 32'hABCD0001);
        check(log_n == 2, "R5 addr 0 count", log_n, 2);
        clear_phys(); ack_lat = 3;
        add_phy(31, 1, 16'h1234, 16'h0000);
        run_scan(-1);
        check(found && phy_addr == 5'd31 && phy_id == 32'h12340000, "R4 addr 31", phy_id, 32'h12340000);
        check(log_n == 33, "R2 addr 31 count", log_n, 33);
    endtask

    task automatic t_slow();
        clear_phys(); ack_lat = 1;
        add_phy(9, 3, 16'h0181, 16'hB881);
        run_scan(-1);
        check(found && phy_addr == 5'd9, "R6 late phy found", phy_addr, 9);
        check(log_n == 75, "R6 late count", log_n, 75);
        check(gap_n == 2, "R6 gap count", gap_n, 2);
        check(gaps[0] == WAITC && gaps[1] == WAITC, "R6 gap length", gaps[0], WAITC);
        check_sweep("R6 sweep restarts at 0", 64, 10);
    endtask

    task automatic t_none();
        clear_phys(); ack_lat = 1;
        expect_id = 32'h0;
        run_scan(-1);
        check(!found && phy_addr == 5'h1F && phy_id == 0, "R7 none result", {found, phy_addr}, 32'h1F);
        check(log_n == 32 * PASSES, "R7 pass bound", log_n, 32 * PASSES);
        check(gap_n == PASSES - 1, "R7 gaps", gap_n, PASSES - 1);
        check(id_match == 1'b0, "R9 no match when not found", id_match, 0);
    endtask

    task automatic t_busy_start();
        clear_phys(); ack_lat = 1;
        add_phy(20, 1, 16'h0007, 16'hC0F1);
        run_scan(10);
        check(found && phy_addr == 5'd20, "R1 busy start ignored addr", phy_addr, 20);
        check(log_n == 22, "R1 busy start ignored count", log_n, 22);
        check_sweep("R1 single sweep", 0, 21);
    endtask

    task automatic t_two();
        clear_phys(); ack_lat = 2;
        add_phy(7, 1, 16'h1111, 16'h2222);
        add_phy(12, 1, 16'h3333, 16'h4444);
        run_scan(-1);
        check(phy_addr == 5'd7 && phy_id == 32'h11112222, "R5 first responder", phy_addr, 7);
        check(log_n == 9, "R5 stops", log_n, 9);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        clear_phys();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edges();
        t_slow();
        t_none();
        t_busy_start();
        t_two();
        finish_run();
    end
endmodule